// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a delta-sigma converter that returns a 32-bit result over a three-wire serial link. A host pulse on `start` pulls the chip select low. The block then watches the converter's serial output as a status line. While that line is high, a conversion is still running. Once it reads low, the block clocks out the whole word with an internally divided serial clock and samples the data on every rising edge. During the same transfer, it presents a 5-bit speed code, most significant bit first, so that the converter picks up the code on the first five rising edges.

When the word is complete, the block checks the two leading bits. It then publishes the sign, the 24 data bits and the five sub-LSB bits together with a one-cycle `valid` strobe. If the check fails, it raises a framing-error strobe and leaves the published fields unchanged. An optional early abort returns chip select high after a chosen number of serial clocks, which starts the converter's next conversion without reading the rest of the word.

The serial clock idles low. Each of its phases lasts a programmable number of system clocks, and the same interval separates the chip-select fall from the first serial clock edge.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `sdi` is 0, and `busy`, `valid`, `frame_err` and `aborted` are all 0.
- R2: A `start` pulse while idle drives `cs_n` low and `busy` high on the next cycle. `busy` stays high until the cycle in which `valid`, `frame_err` or `aborted` pulses. A `start` pulse while busy has no effect on the frame in progress.
- R3: While `cs_n` is low and no serial clock has been issued yet, `sdo` is checked once per half-period H. No `sck` edge occurs while `sdo` is 1. If `sdo` is already 0, the first `sck` rise comes exactly H system clocks after `cs_n` falls.
- R4: Every high phase and every low phase of `sck` inside a frame lasts H system clocks, where H is `half_per` (0 counts as 1). `sck` is 0 whenever `cs_n` is 1.
- R5: `sdi` carries `speed_code[4]` at the first `sck` rise and `speed_code[3]`..`speed_code[0]` at rises 2 to 5. It changes only while `sck` is low, and it is 0 from the fifth `sck` fall onward.
- R6: `sdo` is sampled on each `sck` rise. A full frame has 32 rises, and the first sample is word bit 31.
- R7: After the 32nd `sck` fall, if word bits 31 and 30 are both 0, `valid` pulses for one cycle. In that same cycle `cs_n` is 1 and `busy` is 0. `sign` is word bit 29, `data` is word bits 28:5 and `sub` is word bits 4:0.
- R8: If word bit 31 or bit 30 is 1, `frame_err` pulses instead of `valid`, and `sign`, `data` and `sub` keep their previous values.
- R9: With `abort_en` high, let N be `abort_bits`, raised to 5 if it is smaller. If N is below 32, `cs_n` rises right after the Nth `sck` fall, `aborted` pulses and no `valid` follows, so exactly N rises are issued. If N is 32 or more, a full read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a readout (ignored while busy) |
| half_per | input | 8 | SCK half-period in system clocks (0 acts as 1) |
| speed_code | input | 5 | Speed code shifted out on SDI, MSB first |
| abort_en | input | 1 | Enable early termination of the frame |
| abort_bits | input | 6 | Number of SCK cycles before early termination |
| cs_n | output | 1 | Chip select to converter, active low |
| sck | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial data to converter |
| sdo | input | 1 | Serial data / status from converter |
| busy | output | 1 | High from start until the frame ends |
| valid | output | 1 | One-cycle strobe: fields updated |
| frame_err | output | 1 | One-cycle strobe: leading bits wrong, word dropped |
| aborted | output | 1 | One-cycle strobe: frame terminated early |
| sign | output | 1 | Sign bit of the last good word |
| data | output | 24 | Result bits of the last good word |
| sub | output | 5 | Sub-LSB bits of the last good word |

## Verification
Two situations are hard to reach from the ports. The first is the status wait, where `sdo` must stay high for many half-periods with chip select low and no clock issued. The converter model in the bench holds its ready flag low across a start and checks that no `sck` edge appears. It then releases the flag partway through the frame, and a second `start` pulse is sent into the running frame. The second is the abort boundary: a sweep of `abort_bits` from 0 to 40 covers the clamp to five clocks, every legal stop point, and the values at and beyond 32 that must fall back to a full read.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HIGH = 2'd2,
      ST_LOW  = 2'd3
   } rd_state_t;
endpackage

// File: rtl/adc_rd_tick.sv
`timescale 1ns/1ps
module adc_rd_tick #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HALF_W-1:0] half_per,
   output logic              tick
);
   logic [HALF_W-1:0] cnt;
   logic [HALF_W-1:0] h_eff;

   assign h_eff = (half_per == '0) ? HALF_W'(1) : half_per;
   assign tick  = en && (cnt == h_eff - HALF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!en || tick)  cnt <= '0;
      else                   cnt <= cnt + HALF_W'(1);
   end

   // R4: with a half-period above one, ticks never come back to back
   p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && h_eff != HALF_W'(1)) |=> !tick);
endmodule

// File: rtl/adc_rd_decode.sv
`timescale 1ns/1ps
module adc_rd_decode #(
   parameter int WORD_W = 32,
   parameter int DATA_W = 24,
   parameter int SUB_W  = 5
) (
   input  logic [WORD_W-1:0] word,
   output logic              ok,
   output logic              sign,
   output logic [DATA_W-1:0] data,
   output logic [SUB_W-1:0]  sub
);
   localparam int SIGN_POS = SUB_W + DATA_W;

   initial begin
      if (3 + DATA_W + SUB_W != WORD_W)
         $error("adc_rd_decode: field widths do not fill the word");
   end

   assign ok   = !word[WORD_W-1] && !word[WORD_W-2];
   assign sign = word[SIGN_POS];
   assign data = word[SIGN_POS-1:SUB_W];
   assign sub  = word[SUB_W-1:0];
endmodule

// File: rtl/adc_rd_abort.sv
`timescale 1ns/1ps
module adc_rd_abort #(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 6,
   parameter int MIN_BITS  = 5,
   parameter bit HAS_ABORT = 1'b1
) (
   input  logic             abort_en,
   input  logic [CNT_W-1:0] abort_bits,
   input  logic [CNT_W-1:0] fall_nx,
   output logic             hit
);
   generate
      if (HAS_ABORT) begin : g_abort
         logic [CNT_W-1:0] lim;
         assign lim = (abort_bits < CNT_W'(MIN_BITS)) ? CNT_W'(MIN_BITS) : abort_bits;
         assign hit = abort_en && (lim < CNT_W'(WORD_W)) && (fall_nx == lim);
      end else begin : g_none
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
   import adc_rd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CODE_W    = 5,
   parameter int DATA_W    = 24,
   parameter int SUB_W     = 5,
   parameter int HALF_W    = 8,
   parameter bit HAS_ABORT = 1'b1,
   localparam int CNT_W    = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [HALF_W-1:0] half_per,
   input  logic [CODE_W-1:0] speed_code,
   input  logic              abort_en,
   input  logic [CNT_W-1:0]  abort_bits,
   output logic              cs_n,
   output logic              sck,
   output logic              sdi,
   input  logic              sdo,
   output logic              busy,
   output logic              valid,
   output logic              frame_err,
   output logic              aborted,
   output logic              sign,
   output logic [DATA_W-1:0] data,
   output logic [SUB_W-1:0]  sub
);
   initial begin
      if (CODE_W < 1 || CODE_W >= WORD_W)
         $error("adc_rd_ctrl: speed code must be shorter than the word");
      if (HALF_W < 1)
         $error("adc_rd_ctrl: half-period width must be positive");
   end

   rd_state_t          state;
   logic [WORD_W-1:0]  sh;
   logic [CNT_W-1:0]   fcnt;
   logic [CNT_W-1:0]   fcnt_nx;
   logic [CODE_W-1:0]  code_sh;
   logic               abort_en_q;
   logic [CNT_W-1:0]   abort_bits_q;
   logic               tick;
   logic               dec_ok;
   logic               dec_sign;
   logic [DATA_W-1:0]  dec_data;
   logic [SUB_W-1:0]   dec_sub;
   logic               abort_hit;

   assign fcnt_nx = fcnt + CNT_W'(1);
   assign sdi     = code_sh[CODE_W-1];

   adc_rd_tick #(.HALF_W(HALF_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(state != ST_IDLE),
      .half_per(half_per), .tick(tick));

   adc_rd_decode #(.WORD_W(WORD_W), .DATA_W(DATA_W), .SUB_W(SUB_W)) u_dec (
      .word(sh), .ok(dec_ok), .sign(dec_sign), .data(dec_data), .sub(dec_sub));

   adc_rd_abort #(.WORD_W(WORD_W), .CNT_W(CNT_W), .MIN_BITS(CODE_W),
                  .HAS_ABORT(HAS_ABORT)) u_abort (
      .abort_en(abort_en_q), .abort_bits(abort_bits_q),
      .fall_nx(fcnt_nx), .hit(abort_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cs_n         <= 1'b1;
         sck          <= 1'b0;
         busy         <= 1'b0;
         valid        <= 1'b0;
         frame_err    <= 1'b0;
         aborted      <= 1'b0;
         sh           <= '0;
         fcnt         <= '0;
         code_sh      <= '0;
         abort_en_q   <= 1'b0;
         abort_bits_q <= '0;
         sign         <= 1'b0;
         data         <= '0;
         sub          <= '0;
      end else begin
         valid     <= 1'b0;
         frame_err <= 1'b0;
         aborted   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state        <= ST_WAIT;
                  cs_n         <= 1'b0;
                  busy         <= 1'b1;
                  fcnt         <= '0;
                  code_sh      <= speed_code;
                  abort_en_q   <= abort_en;
                  abort_bits_q <= abort_bits;
               end
            end
            ST_WAIT: begin
               if (tick && !sdo) begin
                  sck   <= 1'b1;
                  sh    <= {sh[WORD_W-2:0], sdo};
                  state <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sck     <= 1'b0;
                  fcnt    <= fcnt_nx;
                  code_sh <= {code_sh[CODE_W-2:0], 1'b0};
                  if (fcnt_nx == CNT_W'(WORD_W)) begin
                     state <= ST_IDLE;
                     cs_n  <= 1'b1;
                     busy  <= 1'b0;
                     if (dec_ok) begin
                        valid <= 1'b1;
                        sign  <= dec_sign;
                        data  <= dec_data;
                        sub   <= dec_sub;
                     end else begin
                        frame_err <= 1'b1;
                     end
                  end else if (abort_hit) begin
                     state   <= ST_IDLE;
                     cs_n    <= 1'b1;
                     busy    <= 1'b0;
                     aborted <= 1'b1;
                  end else begin
                     state <= ST_LOW;
                  end
               end
            end
            ST_LOW: begin
               if (tick) begin
                  sck   <= 1'b1;
                  sh    <= {sh[WORD_W-2:0], sdo};
                  state <= ST_HIGH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: serial clock held low whenever the device is deselected
   p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);
   // R2: chip select only active inside a busy window
   p_cs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);
   // R5: SDI never moves during a high SCK phase
   p_sdi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sdi));
   // R3: no clock edge while the converter reports a conversion running
   p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && sdo) |=> !sck);
   // R7: result strobe arrives with the link released
   p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (!busy && cs_n && !sck));
   // R8: good and bad word strobes are exclusive
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && frame_err));
   // R9: early termination never before the code has been clocked in
   p_abort_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      aborted |-> (fcnt >= CNT_W'(CODE_W) && fcnt < CNT_W'(WORD_W)));
endmodule

// File: tb/sim_adc_rd_ctrl.sv
`timescale 1ns/1ps
module sim_adc_rd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  half_per = 8'd1;
   logic [4:0]  speed_code = '0;
   logic        abort_en = 1'b0;
   logic [5:0]  abort_bits = '0;
   logic        cs_n, sck, sdi, sdo, busy, valid, frame_err, aborted, sign;
   logic [23:0] data;
   logic [4:0]  sub;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   adc_rd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .half_per(half_per),
      .speed_code(speed_code), .abort_en(abort_en), .abort_bits(abort_bits),
      .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo), .busy(busy),
      .valid(valid), .frame_err(frame_err), .aborted(aborted),
      .sign(sign), .data(data), .sub(sub));

   // converter model
   logic        ready = 1'b0;
   logic [31:0] w = '0;
   int          idx = 0;
   int          rises = 0;
   logic [4:0]  got_code = '0;

   always @(negedge sck or posedge cs_n) begin
      if (cs_n) idx = 0;
      else      idx = idx + 1;
   end
   assign sdo = (cs_n || !ready) ? 1'b1 : ((idx < 32) ? w[31-idx] : 1'b1);
   always @(posedge sck) begin
      if (rises < 5) got_code[4-rises] = sdi;
      rises = rises + 1;
   end

   // timing monitor
   int   setup_len, setup_run, hi_run, lo_run, hi_min, hi_max, lo_min, lo_max;
   int   sdi_bad, n_valid, n_ferr, n_abrt;
   logic seen_rise, sck_p, sdi_p;

   task automatic clr_mon();
      setup_len = -1; setup_run = 0; hi_run = 0; lo_run = 0;
      hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
      sdi_bad = 0; n_valid = 0; n_ferr = 0; n_abrt = 0;
      seen_rise = 1'b0; rises = 0;
   endtask

   always @(negedge clk) begin
      if (sck && !sck_p) begin
         if (lo_run > 0) begin
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
         end
         lo_run = 0;
      end
      if (!sck && sck_p) begin
         if (hi_run < hi_min) hi_min = hi_run;
         if (hi_run > hi_max) hi_max = hi_run;
         hi_run = 0;
      end
      if (!cs_n && !sck && !seen_rise) setup_run++;
      if (sck) begin
         hi_run++;
         if (!seen_rise) begin seen_rise = 1'b1; setup_len = setup_run; end
      end else if (!cs_n && seen_rise) lo_run++;
      if (sck && sck_p && sdi != sdi_p) sdi_bad++;
      if (valid) n_valid++;
      if (frame_err) n_ferr++;
      if (aborted) n_abrt++;
      sck_p = sck; sdi_p = sdi;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // run one frame; poll_gap>0 holds the converter busy for that many cycles
   task automatic frame(input int h, input logic [4:0] code, input logic [31:0] word,
                        input bit aen, input int abits, input int poll_gap);
      int heff, lim, t;
      bit do_abort;
      logic        o_sign;
      logic [23:0] o_data;
      logic [4:0]  o_sub;
      heff = (h == 0) ? 1 : h;
      lim = (abits < 5) ? 5 : abits;
      do_abort = aen && (lim < 32);
      @(posedge clk); #1;
      half_per = 8'(h); speed_code = code; abort_en = aen; abort_bits = 6'(abits);
      w = word; ready = (poll_gap == 0);
      o_sign = sign; o_data = data; o_sub = sub;
      clr_mon();
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      chk(cs_n == 1'b0 && busy == 1'b1, "R2 start", {cs_n, busy}, 2'b01);
      if (poll_gap > 0) begin
         repeat (poll_gap) @(negedge clk);
         chk(rises == 0, "R3 no sck while sdo high", rises, 0);
         chk(cs_n == 1'b0 && busy == 1'b1, "R2 busy while polling", {cs_n, busy}, 2'b01);
         @(posedge clk); #1;
         ready = 1'b1;
         start = 1'b1;        // R2: start while busy must be ignored
         @(posedge clk); #1;
         start = 1'b0;
      end
      t = 0;
      while (n_valid + n_ferr + n_abrt == 0 && t < 20000) begin
         @(negedge clk); t++;
      end
      chk(t < 20000, "R7 frame completes", t, 0);
      chk(cs_n == 1'b1 && busy == 1'b0 && sck == 1'b0, "R7 link released",
          {cs_n, busy, sck}, 3'b100);
      chk(sdi == 1'b0, "R5 sdi low after code", sdi, 0);
      chk(got_code == code, "R5 speed code order", got_code, code);
      chk(sdi_bad == 0, "R5 sdi stable while sck high", sdi_bad, 0);
      chk(hi_min == heff && hi_max == heff, "R4 high phase", {hi_min[15:0], hi_max[15:0]}, heff);
      if (lo_max > 0)
         chk(lo_min == heff && lo_max == heff, "R4 low phase", {lo_min[15:0], lo_max[15:0]}, heff);
      if (poll_gap == 0)
         chk(setup_len == heff, "R3 cs to first sck", setup_len, heff);
      if (do_abort) begin
         chk(n_abrt == 1 && n_valid == 0 && n_ferr == 0, "R9 abort strobe",
             {n_abrt[7:0], n_valid[7:0], n_ferr[7:0]}, 32'h10000);
         chk(rises == lim, "R9 rises before abort", rises, lim);
         chk({sign, data, sub} == {o_sign, o_data, o_sub}, "R9 fields kept",
             {sign, data, sub}, {o_sign, o_data, o_sub});
      end else begin
         chk(rises == 32, "R6 full frame rises", rises, 32);
         if (word[31] || word[30]) begin
            chk(n_ferr == 1 && n_valid == 0, "R8 frame error strobe", {n_ferr, n_valid}, 1);
            chk({sign, data, sub} == {o_sign, o_data, o_sub}, "R8 fields kept",
                {sign, data, sub}, {o_sign, o_data, o_sub});
         end else begin
            chk(n_valid == 1 && n_ferr == 0, "R7 valid strobe", {n_valid, n_ferr}, 1);
            chk(sign == word[29], "R7 sign", sign, word[29]);
            chk(data == word[28:5], "R6 R7 data", data, word[28:5]);
            chk(sub == word[4:0], "R7 sub", sub, word[4:0]);
         end
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #950000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] wd;
      sck_p = 1'b0; sdi_p = 1'b0;
      clr_mon();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cs_n == 1'b1 && sck == 1'b0 && sdi == 1'b0, "R1 link idle",
          {cs_n, sck, sdi}, 3'b100);
      chk(!busy && !valid && !frame_err && !aborted, "R1 strobes low",
          {busy, valid, frame_err, aborted}, 0);
      // sweep of half-period and speed code
      for (int h = 1; h <= 3; h++) begin
         for (int c = 0; c < 32; c++) begin
            wd = (32'(c) * 32'h0123_4577 + 32'(h) * 32'h09E3_779B) ^ 32'h1555_AAAA;
            frame(h, 5'(c), {2'b00, wd[29:0]}, 1'b0, 0, 0);
         end
      end
      frame(2, 5'h1F, 32'h3FFF_FFFF, 1'b0, 0, 0);    // all ones below the flags
      frame(1, 5'h00, 32'h0000_0000, 1'b0, 0, 0);
      frame(0, 5'h0A, 32'h2468_ACE1, 1'b0, 0, 0);    // H=0 acts as 1
      frame(2, 5'h13, 32'h4123_4567, 1'b0, 0, 0);    // R8 bit 30 set
      frame(3, 5'h07, 32'h1ABC_DEF0, 1'b0, 0, 37);   // R3 polling, R2 ignored start
      for (int n = 0; n <= 40; n++)
         frame(1, 5'(n), 32'h0F0F_3C3C ^ 32'(n), 1'b1, n, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule